// File: doc/BRIEF.md
# Configurable Binary-Field Multiplier

This block multiplies two elements of a binary extension field GF(2^m), where m is 5, 6, 7 or 8, and returns one product per clock cycle. The product is formed in two purely combinational stages. A carryless multiplier first builds the full 2m−1 bit polynomial product. A reduction stage then folds the high part of that product back into the field as a GF(2) matrix-vector product, using a matrix that software derives from the chosen irreducible polynomial and writes into a dedicated configuration register.

Every field size uses one fixed array of 8 rows by 7 columns. For a smaller field, the operand bits above m are forced to zero. A size-specific steering network then picks which product bits feed the 7-bit reduction vector and which form the remainder, so that the same array serves every size. While no operation is presented, the operands are forced to zero so that the arithmetic does not toggle. An optional output register, present by default, adds one cycle of latency.

Top module: `gf_cfg_mult`

## Requirements
- R1: After reset, res_out and res_valid are 0, the field size is 8 and the matrix is the one for x^8+x^4+x^3+x+1, so that 0x57 times 0x83 gives 0xC1 without any configuration write.
- R2: With m = 8, when op_valid is 1 in a cycle, res_out in the next cycle is op_a times op_b modulo the loaded polynomial, and res_valid is 1 there.
- R3: A cycle with cfg_we = 1 captures cfg_size and cfg_matrix at the clock edge, and operands presented after that edge use the new setting. The size code is 0, 1, 2 or 3 for m = 5, 6, 7 or 8. Column j (j = 0..6) sits in cfg_matrix[8j+7:8j] and holds x^(m+j) mod r. Columns j ≥ m−1 are unused.
- R4: While cfg_we = 0, changes on cfg_size and cfg_matrix have no effect on results.
- R5: For m < 8, operand bits at or above position m are ignored, and the result equals the product of the low m bits modulo the loaded degree-m polynomial.
- R6: Result bits at or above m read as 0. Matrix column bits at or above m are dropped when the matrix is loaded.
- R7: A cycle with op_valid = 0 yields res_out = 0 and res_valid = 0 in the next cycle, whatever the operand values are.
- R8: Operations presented in consecutive cycles each produce a correct result, one per cycle, with no stall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_size | input | 2 | Field size code (0..3 gives m = 5..8) |
| cfg_matrix | input | 56 | Reduction matrix, seven 8-bit columns |
| op_valid | input | 1 | Operands present this cycle |
| op_a | input | 8 | First operand |
| op_b | input | 8 | Second operand |
| res_out | output | 8 | Field product |
| res_valid | output | 1 | res_out holds a product |

## Verification
The hardest case to reach is a narrow field whose loaded matrix carries stray bits above position m while both operands carry stray high bits. A wrong steering of the product or a missing mask only shows up when all of these are present together. The bench builds each matrix itself by long division of x^(m+j) by a random polynomial. For m of 5, 6 and 7 it ORs random garbage into the unused column bits and into the operands. It then compares every result with a bit-by-bit shift-and-reduce model, and separately checks that the bits above m are zero.

// File: rtl/gf_cfg_pkg.sv
package gf_cfg_pkg;
  localparam int GF_MAX_W    = 8;
  localparam int GF_MIN_W    = 5;
  localparam int GF_NUM_SZ   = GF_MAX_W - GF_MIN_W + 1;
  localparam int GF_CODE_W   = (GF_NUM_SZ > 1) ? $clog2(GF_NUM_SZ) : 1;
  localparam logic [GF_MAX_W-1:0] GF_DEF_POLY = 8'h1B;

  typedef enum logic [GF_CODE_W-1:0] {
    GF_SZ5 = 2'd0,
    GF_SZ6 = 2'd1,
    GF_SZ7 = 2'd2,
    GF_SZ8 = 2'd3
  } gf_size_e;
endpackage

// File: rtl/gf_cfg_store.sv
module gf_cfg_store #(
  parameter int MAX_W = gf_cfg_pkg::GF_MAX_W,
  parameter int MIN_W = gf_cfg_pkg::GF_MIN_W,
  parameter int CODE_W = gf_cfg_pkg::GF_CODE_W,
  parameter logic [MAX_W-1:0] DEF_POLY = gf_cfg_pkg::GF_DEF_POLY,
  localparam int RED_W = MAX_W - 1,
  localparam int MAT_W = MAX_W * RED_W,
  localparam int NUM_SZ = MAX_W - MIN_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [CODE_W-1:0] cfg_size,
  input  logic [MAT_W-1:0]  cfg_matrix,
  output logic [CODE_W-1:0] size_q,
  output logic [MAT_W-1:0]  matrix_q,
  output logic [MAX_W-1:0]  mask_q
);
  function automatic logic [MAX_W-1:0] mask_for(input int m);
    logic [MAX_W-1:0] mk;
    mk = '0;
    for (int i = 0; i < MAX_W; i++) if (i < m) mk[i] = 1'b1;
    return mk;
  endfunction

  // multiply a residue by x and fold x^m back as the low polynomial
  function automatic logic [MAX_W-1:0] times_x(input logic [MAX_W-1:0] cur,
                                               input logic [MAX_W-1:0] rlow,
                                               input int m);
    logic carry;
    carry = cur[m-1];
    return ((cur << 1) & mask_for(m)) ^ (carry ? (rlow & mask_for(m)) : '0);
  endfunction

  function automatic logic [MAT_W-1:0] build_matrix(input logic [MAX_W-1:0] rlow,
                                                    input int m);
    logic [MAT_W-1:0] mat;
    logic [MAX_W-1:0] col;
    mat = '0;
    col = rlow & mask_for(m);
    for (int j = 0; j < RED_W; j++) begin
      mat[j*MAX_W +: MAX_W] = col;
      col = times_x(col, rlow, m);
    end
    return mat;
  endfunction

  localparam logic [MAT_W-1:0]  DEF_MATRIX = build_matrix(DEF_POLY, MAX_W);
  localparam logic [CODE_W-1:0] DEF_CODE   = CODE_W'(NUM_SZ - 1);

  logic [MAX_W-1:0] wr_mask;
  logic [MAT_W-1:0] wr_matrix;

  assign wr_mask = mask_for(MIN_W + int'(cfg_size));

  for (genvar j = 0; j < RED_W; j++) begin : g_col
    assign wr_matrix[j*MAX_W +: MAX_W] = cfg_matrix[j*MAX_W +: MAX_W] & wr_mask;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      size_q   <= DEF_CODE;
      matrix_q <= DEF_MATRIX;
    end else if (cfg_we) begin
      size_q   <= cfg_size;
      matrix_q <= wr_matrix;
    end
  end

  assign mask_q = mask_for(MIN_W + int'(size_q));

  // R3: a write strobe captures the size code
  assert_cfg_capture_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we |=> size_q == $past(cfg_size));

  // R4: without a strobe the configuration stays put
  assert_cfg_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_we |=> ($stable(matrix_q) && $stable(size_q)));
endmodule

// File: rtl/gf_clmul.sv
module gf_clmul #(
  parameter int MAX_W = gf_cfg_pkg::GF_MAX_W,
  localparam int PROD_W = 2 * MAX_W - 1
) (
  input  logic [MAX_W-1:0]  a,
  input  logic [MAX_W-1:0]  b,
  output logic [PROD_W-1:0] prod
);
  logic [PROD_W-1:0] pp [MAX_W];

  // one shifted, gated copy of a per bit of b
  for (genvar i = 0; i < MAX_W; i++) begin : g_pp
    assign pp[i] = b[i] ? (PROD_W'(a) << i) : '0;
  end

  function automatic logic [PROD_W-1:0] xor_fold(input logic [PROD_W-1:0] v [MAX_W]);
    logic [PROD_W-1:0] acc;
    acc = '0;
    for (int i = 0; i < MAX_W; i++) acc ^= v[i];
    return acc;
  endfunction

  assign prod = xor_fold(pp);
endmodule

// File: rtl/gf_prod_map.sv
module gf_prod_map #(
  parameter int MAX_W = gf_cfg_pkg::GF_MAX_W,
  parameter int MIN_W = gf_cfg_pkg::GF_MIN_W,
  parameter int CODE_W = gf_cfg_pkg::GF_CODE_W,
  localparam int PROD_W = 2 * MAX_W - 1,
  localparam int RED_W = MAX_W - 1,
  localparam int NUM_SZ = MAX_W - MIN_W + 1
) (
  input  logic [PROD_W-1:0] prod,
  input  logic [CODE_W-1:0] size,
  output logic [RED_W-1:0]  red_vec,
  output logic [MAX_W-1:0]  rem_vec
);
  logic [RED_W-1:0] cand_red [NUM_SZ];
  logic [MAX_W-1:0] cand_rem [NUM_SZ];

  // per size: bits m..2m-2 feed the reduction vector, bits 0..m-1 stay
  for (genvar s = 0; s < NUM_SZ; s++) begin : g_size
    localparam int M = MIN_W + s;
    assign cand_red[s] = RED_W'(prod[2*M-2:M]);
    assign cand_rem[s] = MAX_W'(prod[M-1:0]);
  end

  always_comb begin
    red_vec = '0;
    rem_vec = '0;
    for (int s = 0; s < NUM_SZ; s++) begin
      if (size == CODE_W'(s)) begin
        red_vec = cand_red[s];
        rem_vec = cand_rem[s];
      end
    end
  end
endmodule

// File: rtl/gf_reduce.sv
module gf_reduce #(
  parameter int MAX_W = gf_cfg_pkg::GF_MAX_W,
  localparam int RED_W = MAX_W - 1,
  localparam int MAT_W = MAX_W * RED_W
) (
  input  logic [RED_W-1:0] red_vec,
  input  logic [MAX_W-1:0] rem_vec,
  input  logic [MAT_W-1:0] matrix,
  output logic [MAX_W-1:0] result
);
  logic [MAX_W-1:0] term [RED_W];

  for (genvar j = 0; j < RED_W; j++) begin : g_term
    assign term[j] = red_vec[j] ? matrix[j*MAX_W +: MAX_W] : '0;
  end

  function automatic logic [MAX_W-1:0] fold(input logic [MAX_W-1:0] base,
                                            input logic [MAX_W-1:0] t [RED_W]);
    logic [MAX_W-1:0] acc;
    acc = base;
    for (int j = 0; j < RED_W; j++) acc ^= t[j];
    return acc;
  endfunction

  assign result = fold(rem_vec, term);
endmodule

// File: rtl/gf_cfg_mult.sv
module gf_cfg_mult #(
  parameter int MAX_W = gf_cfg_pkg::GF_MAX_W,
  parameter int MIN_W = gf_cfg_pkg::GF_MIN_W,
  parameter int CODE_W = gf_cfg_pkg::GF_CODE_W,
  parameter bit OUT_REG = 1'b1,
  parameter logic [MAX_W-1:0] DEF_POLY = gf_cfg_pkg::GF_DEF_POLY,
  localparam int RED_W = MAX_W - 1,
  localparam int MAT_W = MAX_W * RED_W,
  localparam int PROD_W = 2 * MAX_W - 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [CODE_W-1:0] cfg_size,
  input  logic [MAT_W-1:0]  cfg_matrix,
  input  logic              op_valid,
  input  logic [MAX_W-1:0]  op_a,
  input  logic [MAX_W-1:0]  op_b,
  output logic [MAX_W-1:0]  res_out,
  output logic              res_valid
);
  logic [CODE_W-1:0] size_q;
  logic [MAT_W-1:0]  matrix_q;
  logic [MAX_W-1:0]  mask_q;
  logic [MAX_W-1:0]  opnd_a, opnd_b;
  logic [PROD_W-1:0] full_prod;
  logic [RED_W-1:0]  red_vec;
  logic [MAX_W-1:0]  rem_vec;
  logic [MAX_W-1:0]  reduced;

  gf_cfg_store #(.MAX_W(MAX_W), .MIN_W(MIN_W), .CODE_W(CODE_W), .DEF_POLY(DEF_POLY)) u_store (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_size(cfg_size),
    .cfg_matrix(cfg_matrix), .size_q(size_q), .matrix_q(matrix_q), .mask_q(mask_q)
  );

  // idle gating and narrow-field masking of the operands
  assign opnd_a = op_valid ? (op_a & mask_q) : '0;
  assign opnd_b = op_valid ? (op_b & mask_q) : '0;

  gf_clmul #(.MAX_W(MAX_W)) u_clmul (.a(opnd_a), .b(opnd_b), .prod(full_prod));

  gf_prod_map #(.MAX_W(MAX_W), .MIN_W(MIN_W), .CODE_W(CODE_W)) u_map (
    .prod(full_prod), .size(size_q), .red_vec(red_vec), .rem_vec(rem_vec)
  );

  gf_reduce #(.MAX_W(MAX_W)) u_reduce (
    .red_vec(red_vec), .rem_vec(rem_vec), .matrix(matrix_q), .result(reduced)
  );

  if (OUT_REG) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        res_out   <= '0;
        res_valid <= 1'b0;
      end else begin
        res_out   <= reduced;
        res_valid <= op_valid;
      end
    end
  end else begin : g_comb
    assign res_out   = reduced;
    assign res_valid = op_valid;
  end

  // R5: the steering never uses reduction positions beyond m-2
  assert_map_fill_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (red_vec & ~RED_W'(mask_q >> 1)) == '0);

  // R6: no result bit at or above the field width
  assert_upper_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (reduced & ~mask_q) == '0);

  // R7: an idle cycle produces a zero product
  assert_idle_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !op_valid |-> reduced == '0);
endmodule

// File: tb/gf_cfg_mult_test.sv
module gf_cfg_mult_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_size = 2'd3;
  logic [55:0] cfg_matrix = '0;
  logic        op_valid = 1'b0;
  logic [7:0]  op_a = '0, op_b = '0;
  logic [7:0]  res_out;
  logic        res_valid;

  int tests = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  gf_cfg_mult uut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_size(cfg_size),
    .cfg_matrix(cfg_matrix), .op_valid(op_valid), .op_a(op_a), .op_b(op_b),
    .res_out(res_out), .res_valid(res_valid)
  );

  function automatic logic [7:0] low_mask(input int m);
    return 8'((9'd1 << m) - 9'd1);
  endfunction

  // bit-serial shift-and-reduce reference
  function automatic logic [7:0] ref_mul(input logic [7:0] a, input logic [7:0] b,
                                         input int m, input logic [7:0] rlow);
    logic [8:0] poly, acc;
    logic [7:0] am, bm;
    am = a & low_mask(m);
    bm = b & low_mask(m);
    poly = (9'd1 << m) | {1'b0, rlow & low_mask(m)};
    acc = '0;
    for (int i = m - 1; i >= 0; i--) begin
      acc = acc << 1;
      if (acc[m]) acc ^= poly;
      if (bm[i]) acc ^= {1'b0, am};
    end
    return acc[7:0];
  endfunction

  // x^(m+j) mod r by long division
  function automatic logic [7:0] ref_col(input int m, input logic [7:0] rlow, input int j);
    logic [15:0] v, poly;
    poly = (16'd1 << m) | {8'd0, rlow & low_mask(m)};
    v = 16'd1 << (m + j);
    for (int k = 15; k >= m; k--) if (v[k]) v ^= poly << (k - m);
    return v[7:0];
  endfunction

  function automatic logic [55:0] make_mat(input int m, input logic [7:0] rlow,
                                           input bit junk);
    logic [55:0] mat;
    for (int j = 0; j < 7; j++) begin
      mat[j*8 +: 8] = ref_col(m, rlow, j) |
                      (junk ? (8'($urandom) & ~low_mask(m)) : 8'h00);
    end
    return mat;
  endfunction

  task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %02h expected %02h", req, got, exp);
    end
  endtask

  task automatic load_cfg(input logic [1:0] code, input logic [55:0] mat);
    @(negedge clk);
    op_valid = 1'b0;
    cfg_we = 1'b1;
    cfg_size = code;
    cfg_matrix = mat;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic mul_check(input string req, input logic [7:0] a, input logic [7:0] b,
                           input int m, input logic [7:0] rlow);
    op_valid = 1'b1;
    op_a = a;
    op_b = b;
    @(negedge clk);
    check(req, res_out, ref_mul(a, b, m, rlow));
    check(req, {7'd0, res_valid}, 8'd1);
  endtask

  task automatic test_reset;
    @(negedge clk);
    check("R1 reset res_out", res_out, 8'h00);
    check("R1 reset res_valid", {7'd0, res_valid}, 8'd0);
    op_valid = 1'b1; op_a = 8'h57; op_b = 8'h83;
    @(negedge clk);
    check("R1 default field", res_out, 8'hC1);
    op_valid = 1'b0;
  endtask

  task automatic test_full_width;
    logic [7:0] r;
    r = 8'($urandom) | 8'h01;
    load_cfg(2'd3, make_mat(8, r, 1'b0));
    for (int i = 0; i < 30; i++) mul_check("R2 m=8 product", 8'($urandom), 8'($urandom), 8, r);
    op_valid = 1'b0;
  endtask

  task automatic test_stream;
    logic [7:0] r;
    r = 8'h1D;
    load_cfg(2'd3, make_mat(8, r, 1'b0));
    for (int i = 0; i < 16; i++) mul_check("R8 back-to-back", 8'(i * 17 + 3), 8'(255 - i * 13), 8, r);
    op_valid = 1'b0;
  endtask

  task automatic test_small_sizes;
    for (int code = 0; code < 3; code++) begin
      int m;
      logic [7:0] r, a, b;
      m = 5 + code;
      r = (8'($urandom) & low_mask(m)) | 8'h01;
      load_cfg(2'(code), make_mat(m, r, 1'b1));
      for (int i = 0; i < 20; i++) begin
        a = 8'($urandom);
        b = 8'($urandom);
        mul_check("R5 narrow field", a, b, m, r);
        check("R6 upper bits zero", res_out & ~low_mask(m), 8'h00);
      end
      mul_check("R5 all ones", 8'hFF, 8'hFF, m, r);
      mul_check("R5 identity", 8'hE1, 8'h01 | ~low_mask(m), m, r);
      mul_check("R5 zero operand", ~low_mask(m), 8'hFF, m, r);
    end
    op_valid = 1'b0;
  endtask

  task automatic test_cfg_switch;
    load_cfg(2'd1, make_mat(6, 8'h03, 1'b0));
    mul_check("R3 new size applies", 8'h2B, 8'h3E, 6, 8'h03);
    load_cfg(2'd3, make_mat(8, 8'h4D, 1'b0));
    mul_check("R3 switch back to m=8", 8'hA7, 8'h9C, 8, 8'h4D);
    op_valid = 1'b0;
  endtask

  task automatic test_hold;
    load_cfg(2'd2, make_mat(7, 8'h09, 1'b0));
    @(negedge clk);
    cfg_size = 2'd0;
    cfg_matrix = {7{8'hA5}};
    for (int i = 0; i < 8; i++) begin
      mul_check("R4 config held", 8'($urandom), 8'($urandom), 7, 8'h09);
      cfg_matrix = 56'($urandom) << 20 ^ 56'($urandom);
    end
    op_valid = 1'b0;
  endtask

  task automatic test_idle;
    load_cfg(2'd3, make_mat(8, 8'h1B, 1'b0));
    op_valid = 1'b1; op_a = 8'h3C; op_b = 8'h77;
    @(negedge clk);
    op_valid = 1'b0; op_a = 8'hFF; op_b = 8'hFF;
    @(negedge clk);
    check("R7 idle res_out", res_out, 8'h00);
    check("R7 idle res_valid", {7'd0, res_valid}, 8'd0);
    mul_check("R7 resume after idle", 8'h3C, 8'h77, 8, 8'h1B);
    op_valid = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    test_reset();
    test_full_width();
    test_stream();
    test_small_sizes();
    test_cfg_switch();
    test_hold();
    test_idle();
    done = 1'b1;
  end

  initial begin
    for (int c = 0; c < 20000 && !done; c++) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog: run did not complete");
    end
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule